// File: doc/BRIEF.md
# Keyboard Controller Command Processor

This block is the host side of a PC-style keyboard controller. The host sees two byte-wide ports, a command/status port and a data port. A byte written to the command port is decoded in the same cycle. The command either acts at once (it changes a register bit, pulses a reset request or produces a reply byte) or arms a pending write. An armed write steers the next data-port byte into the mode register, into the output port, into the reply queue, or out to the auxiliary device.

The block holds three registers: the mode register, the status register and the output port. Two availability inputs tell the block that keyboard data or auxiliary data is waiting in the downstream queues. From these inputs and the mode bits the block forms the buffer-full flags in the status and output port views and the two interrupt outputs. Reply bytes leave on a one-cycle push toward the keyboard or auxiliary output queue. Device-bound bytes leave on a separate one-cycle push. Output port bit 1 drives the A20 gate, and clearing output port bit 0 asks for a system reset.

Top module: `kbc_cmd_proc`

## Requirements
- R1: After reset, mode_o is 0x03, status_o is 0x18 (with no data available), outport_o is 0x03 and a20_o is 1. No push, reset request or error strobe is active.
- R2: Every registered effect appears on the cycle after the write strobe, including pushes, strobes and register changes. Command 0x20 pushes the mode value. Command 0xAA sets status bit 2 and pushes 0x55. Commands 0xA9, 0xAB and 0xC0 each push 0x00. Command 0xD0 pushes the output port value as outport_o shows it. Replies are pushed with rq_aux=0.
- R3: Command 0xA7 sets mode bit 5 and command 0xA8 clears it. Command 0xAD sets mode bit 4 and command 0xAE clears it. No other bit changes.
- R4: Command 0xDF sets output port bit 1 and drives a20_o high. Command 0xDD clears bit 1 and drives a20_o low.
- R5: Any command 0xF0..0xFF with bit 0 clear, 0xFE among them, produces a one-cycle sys_rst_req pulse. The same range with bit 0 set has no effect.
- R6: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 give no immediate output. They arm the next data-port byte, which then goes to one place: 0x60 loads the mode register, 0xD1 loads the output port, 0xD2 pushes the byte with rq_aux=0, 0xD3 pushes it with rq_aux=1, and 0xD4 sends it out as dev_push with dev_aux=1. The pending write is then cleared.
- R7: A data write with nothing pending goes out as dev_push with dev_aux=0 and the byte on dev_byte.
- R8: Any other command code pulses bad_cmd for one cycle. It changes no register and pushes nothing.
- R9: Status bit 0 and output port bit 4 equal kbd_avail OR aux_avail. Status bit 5 and output port bit 5 equal aux_avail AND NOT kbd_avail. Keyboard data takes priority.
- R10: irq_kbd = kbd_avail AND mode bit 0 AND NOT mode bit 4. irq_aux = aux_avail AND NOT kbd_avail AND mode bit 1.
- R11: A command write and a data write may arrive in the same cycle. The data byte is handled against the write that was pending before that cycle. The command's bit changes then apply on top of the value the data byte loaded, and the command may arm a new pending write.
- R12: A data write that pushes to the reply queue may meet a command with a reply in the same cycle. The data byte is pushed and the command reply is dropped.
- R13: A data write to the output port with value bit 0 clear produces a one-cycle sys_rst_req pulse. a20_o follows value bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command port write strobe |
| cmd_byte | input | 8 | Command byte |
| dat_wr | input | 1 | Data port write strobe |
| dat_byte | input | 8 | Data byte |
| kbd_avail | input | 1 | Keyboard output queue holds data |
| aux_avail | input | 1 | Auxiliary output queue holds data |
| status_o | output | 8 | Status view read on the command port |
| mode_o | output | 8 | Mode register |
| outport_o | output | 8 | Output port view |
| a20_o | output | 1 | A20 gate |
| sys_rst_req | output | 1 | One-cycle system reset request |
| bad_cmd | output | 1 | One-cycle strobe for an unsupported command |
| irq_kbd | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Auxiliary interrupt level |
| rq_push | output | 1 | Push a byte into an output queue |
| rq_byte | output | 8 | Byte pushed |
| rq_aux | output | 1 | 1 selects the auxiliary queue |
| dev_push | output | 1 | Forward a byte to a device |
| dev_byte | output | 8 | Byte forwarded |
| dev_aux | output | 1 | 1 selects the auxiliary device |

## Verification
The two functions that can fall in one cycle are the completion of an armed data write and the decode of a new command. The bench provokes this by raising both strobes together. In one case a mode load meets a mode-bit command. In another a mode load meets a re-arming command, whose re-arm is confirmed by the next data byte. In a third a queue push meets a reply-producing command. The result is judged against R11 and R12: the final register value must be the data byte with the command's bit changes on top, and only the data byte may be pushed, with no reply on the following cycle.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

   localparam int BYTE_W = 8;

   // command codes
   localparam logic [BYTE_W-1:0] OP_RD_MODE  = 8'h20;
   localparam logic [BYTE_W-1:0] OP_WR_MODE  = 8'h60;
   localparam logic [BYTE_W-1:0] OP_AUX_OFF  = 8'hA7;
   localparam logic [BYTE_W-1:0] OP_AUX_ON   = 8'hA8;
   localparam logic [BYTE_W-1:0] OP_AUX_TST  = 8'hA9;
   localparam logic [BYTE_W-1:0] OP_SELF_TST = 8'hAA;
   localparam logic [BYTE_W-1:0] OP_KBD_TST  = 8'hAB;
   localparam logic [BYTE_W-1:0] OP_KBD_OFF  = 8'hAD;
   localparam logic [BYTE_W-1:0] OP_KBD_ON   = 8'hAE;
   localparam logic [BYTE_W-1:0] OP_RD_INP   = 8'hC0;
   localparam logic [BYTE_W-1:0] OP_RD_OUTP  = 8'hD0;
   localparam logic [BYTE_W-1:0] OP_WR_OUTP  = 8'hD1;
   localparam logic [BYTE_W-1:0] OP_WR_KBUF  = 8'hD2;
   localparam logic [BYTE_W-1:0] OP_WR_ABUF  = 8'hD3;
   localparam logic [BYTE_W-1:0] OP_WR_ADEV  = 8'hD4;
   localparam logic [BYTE_W-1:0] OP_GATE_LO  = 8'hDD;
   localparam logic [BYTE_W-1:0] OP_GATE_HI  = 8'hDF;
   localparam logic [BYTE_W-1:0] OP_CPU_RST  = 8'hFE;
   localparam logic [BYTE_W-1:0] OP_IDLE     = 8'hFF;
   localparam logic [3:0]        PULSE_NIB   = 4'hF;

   // bit positions decoded by neighbours
   localparam int MB_KBD_IRQ = 0;
   localparam int MB_AUX_IRQ = 1;
   localparam int MB_KBD_DIS = 4;
   localparam int MB_AUX_DIS = 5;
   localparam int SB_OBF     = 0;
   localparam int SB_SELF    = 2;
   localparam int SB_AOBF    = 5;
   localparam int OB_NRST    = 0;
   localparam int OB_GATE    = 1;
   localparam int OB_OBF     = 4;
   localparam int OB_AOBF    = 5;

   typedef enum logic [2:0] {
      PW_NONE, PW_MODE, PW_OUTP, PW_KBUF, PW_ABUF, PW_ADEV
   } pend_e;

   typedef enum logic [2:0] {
      RP_NONE, RP_MODE, RP_OUTP, RP_TEST, RP_SELF
   } reply_e;

   typedef struct packed {
      logic              known;
      logic              arm;
      pend_e             arm_sel;
      reply_e            reply;
      logic              set_self;
      logic [BYTE_W-1:0] mode_set;
      logic [BYTE_W-1:0] mode_clr;
      logic [BYTE_W-1:0] outp_set;
      logic [BYTE_W-1:0] outp_clr;
      logic              rst_req;
   } cmd_act_t;

endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
   import kbc_pkg::*;
(
   input  logic [BYTE_W-1:0] code_i,
   output cmd_act_t          act_o
);

   localparam logic [BYTE_W-1:0] ONE = 1;

   logic [BYTE_W-1:0] code_f;

   always_comb begin
      code_f = code_i;
      if (code_i[BYTE_W-1 -: 4] == PULSE_NIB)
         code_f = code_i[0] ? OP_IDLE : OP_CPU_RST;
   end

   always_comb begin
      act_o         = '0;
      act_o.known   = 1'b1;
      act_o.arm_sel = PW_NONE;
      act_o.reply   = RP_NONE;
      case (code_f)
         OP_RD_MODE:  act_o.reply = RP_MODE;
         OP_WR_MODE:  begin act_o.arm = 1'b1; act_o.arm_sel = PW_MODE; end
         OP_WR_OUTP:  begin act_o.arm = 1'b1; act_o.arm_sel = PW_OUTP; end
         OP_WR_KBUF:  begin act_o.arm = 1'b1; act_o.arm_sel = PW_KBUF; end
         OP_WR_ABUF:  begin act_o.arm = 1'b1; act_o.arm_sel = PW_ABUF; end
         OP_WR_ADEV:  begin act_o.arm = 1'b1; act_o.arm_sel = PW_ADEV; end
         OP_AUX_OFF:  act_o.mode_set = ONE << MB_AUX_DIS;
         OP_AUX_ON:   act_o.mode_clr = ONE << MB_AUX_DIS;
         OP_KBD_OFF:  act_o.mode_set = ONE << MB_KBD_DIS;
         OP_KBD_ON:   act_o.mode_clr = ONE << MB_KBD_DIS;
         OP_AUX_TST,
         OP_KBD_TST,
         OP_RD_INP:   act_o.reply = RP_TEST;
         OP_SELF_TST: begin act_o.reply = RP_SELF; act_o.set_self = 1'b1; end
         OP_RD_OUTP:  act_o.reply = RP_OUTP;
         OP_GATE_HI:  act_o.outp_set = ONE << OB_GATE;
         OP_GATE_LO:  act_o.outp_clr = ONE << OB_GATE;
         OP_CPU_RST:  act_o.rst_req = 1'b1;
         OP_IDLE:     ;
         default:     act_o.known = 1'b0;
      endcase
   end

endmodule

// File: rtl/kbc_avail_view.sv
module kbc_avail_view
   import kbc_pkg::*;
(
   input  logic              kbd_avail,
   input  logic              aux_avail,
   input  logic [BYTE_W-1:0] mode_q,
   input  logic [BYTE_W-1:0] stat_q,
   input  logic [BYTE_W-1:0] outp_q,
   output logic [BYTE_W-1:0] status_v,
   output logic [BYTE_W-1:0] outp_v,
   output logic              irq_kbd,
   output logic              irq_aux
);

   localparam logic [BYTE_W-1:0] ONE    = 1;
   localparam logic [BYTE_W-1:0] S_MASK = (ONE << SB_OBF) | (ONE << SB_AOBF);
   localparam logic [BYTE_W-1:0] O_MASK = (ONE << OB_OBF) | (ONE << OB_AOBF);

   logic any_full, aux_only;

   assign any_full = kbd_avail | aux_avail;
   assign aux_only = aux_avail & ~kbd_avail;

   always_comb begin
      status_v          = stat_q & ~S_MASK;
      status_v[SB_OBF]  = any_full;
      status_v[SB_AOBF] = aux_only;
      outp_v            = outp_q & ~O_MASK;
      outp_v[OB_OBF]    = any_full;
      outp_v[OB_AOBF]   = aux_only;
   end

   assign irq_kbd = kbd_avail & mode_q[MB_KBD_IRQ] & ~mode_q[MB_KBD_DIS];
   assign irq_aux = aux_only & mode_q[MB_AUX_IRQ];

endmodule

// File: rtl/kbc_ctl_regs.sv
module kbc_ctl_regs
   import kbc_pkg::*;
#(
   parameter logic [BYTE_W-1:0] MODE_RST    = 8'h03,
   parameter logic [BYTE_W-1:0] STAT_RST    = 8'h18,
   parameter logic [BYTE_W-1:0] OUTP_RST    = 8'h03,
   parameter logic [BYTE_W-1:0] SELF_REPLY  = 8'h55,
   parameter logic [BYTE_W-1:0] TEST_REPLY  = 8'h00,
   parameter bit                DATA_FIRST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  cmd_act_t          act,
   input  logic              dat_wr,
   input  logic [BYTE_W-1:0] dat_byte,
   input  logic [BYTE_W-1:0] outp_view,
   output logic [BYTE_W-1:0] mode_q,
   output logic [BYTE_W-1:0] stat_q,
   output logic [BYTE_W-1:0] outp_q,
   output logic              rq_push,
   output logic [BYTE_W-1:0] rq_byte,
   output logic              rq_aux,
   output logic              dev_push,
   output logic [BYTE_W-1:0] dev_byte,
   output logic              dev_aux,
   output logic              sys_rst_req,
   output logic              bad_cmd
);

   localparam logic [BYTE_W-1:0] ONE = 1;

   pend_e             pend_q, pend_n;
   logic [BYTE_W-1:0] mode_base, outp_base, mode_n, outp_n, stat_n;
   logic              ld_mode, ld_outp, run;
   logic              d_push, d_aux, c_push;
   logic [BYTE_W-1:0] c_byte;
   logic              push_n, aux_n;
   logic [BYTE_W-1:0] byte_n;

   assign run     = cmd_wr & act.known;
   assign ld_mode = dat_wr & (pend_q == PW_MODE);
   assign ld_outp = dat_wr & (pend_q == PW_OUTP);

   // data phase first, then command bit changes on top
   always_comb begin
      mode_base = ld_mode ? dat_byte : mode_q;
      outp_base = ld_outp ? dat_byte : outp_q;
      mode_n    = mode_base;
      outp_n    = outp_base;
      stat_n    = stat_q;
      if (run) begin
         mode_n = (mode_base & ~act.mode_clr) | act.mode_set;
         outp_n = (outp_base & ~act.outp_clr) | act.outp_set;
         if (act.set_self) stat_n = stat_q | (ONE << SB_SELF);
      end
   end

   always_comb begin
      pend_n = pend_q;
      if (dat_wr)          pend_n = PW_NONE;
      if (run && act.arm)  pend_n = act.arm_sel;
   end

   // reply sources
   assign d_push = dat_wr & ((pend_q == PW_KBUF) | (pend_q == PW_ABUF));
   assign d_aux  = (pend_q == PW_ABUF);
   assign c_push = run & (act.reply != RP_NONE);

   always_comb begin
      case (act.reply)
         RP_MODE: c_byte = mode_q;
         RP_OUTP: c_byte = outp_view;
         RP_SELF: c_byte = SELF_REPLY;
         default: c_byte = TEST_REPLY;
      endcase
   end

   generate
      if (DATA_FIRST) begin : g_data_first
         always_comb begin
            if (d_push) begin
               push_n = 1'b1; byte_n = dat_byte; aux_n = d_aux;
            end else begin
               push_n = c_push; byte_n = c_byte; aux_n = 1'b0;
            end
         end
      end else begin : g_cmd_first
         always_comb begin
            if (c_push) begin
               push_n = 1'b1; byte_n = c_byte; aux_n = 1'b0;
            end else begin
               push_n = d_push; byte_n = dat_byte; aux_n = d_aux;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q      <= MODE_RST;
         stat_q      <= STAT_RST;
         outp_q      <= OUTP_RST;
         pend_q      <= PW_NONE;
         rq_push     <= 1'b0;
         rq_byte     <= '0;
         rq_aux      <= 1'b0;
         dev_push    <= 1'b0;
         dev_byte    <= '0;
         dev_aux     <= 1'b0;
         sys_rst_req <= 1'b0;
         bad_cmd     <= 1'b0;
      end else begin
         mode_q      <= mode_n;
         stat_q      <= stat_n;
         outp_q      <= outp_n;
         pend_q      <= pend_n;
         rq_push     <= push_n;
         rq_byte     <= byte_n;
         rq_aux      <= aux_n;
         dev_push    <= dat_wr & ((pend_q == PW_NONE) | (pend_q == PW_ADEV));
         dev_byte    <= dat_byte;
         dev_aux     <= (pend_q == PW_ADEV);
         sys_rst_req <= (run & act.rst_req) | (ld_outp & ~dat_byte[OB_NRST]);
         bad_cmd     <= cmd_wr & ~act.known;
      end
   end

endmodule

// File: rtl/kbc_cmd_proc.sv
module kbc_cmd_proc
   import kbc_pkg::*;
#(
   parameter logic [BYTE_W-1:0] MODE_RST   = 8'h03,
   parameter logic [BYTE_W-1:0] STAT_RST   = 8'h18,
   parameter logic [BYTE_W-1:0] OUTP_RST   = 8'h03,
   parameter logic [BYTE_W-1:0] SELF_REPLY = 8'h55,
   parameter logic [BYTE_W-1:0] TEST_REPLY = 8'h00,
   parameter bit                HAS_GATE   = 1'b1,
   parameter bit                DATA_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [BYTE_W-1:0] cmd_byte,
   input  logic              dat_wr,
   input  logic [BYTE_W-1:0] dat_byte,
   input  logic              kbd_avail,
   input  logic              aux_avail,
   output logic [BYTE_W-1:0] status_o,
   output logic [BYTE_W-1:0] mode_o,
   output logic [BYTE_W-1:0] outport_o,
   output logic              a20_o,
   output logic              sys_rst_req,
   output logic              bad_cmd,
   output logic              irq_kbd,
   output logic              irq_aux,
   output logic              rq_push,
   output logic [BYTE_W-1:0] rq_byte,
   output logic              rq_aux,
   output logic              dev_push,
   output logic [BYTE_W-1:0] dev_byte,
   output logic              dev_aux
);

   // elaboration-time parameter checks
   if (OUTP_RST[OB_NRST] == 1'b0) begin : g_bad_outp_rst
      $error("OUTP_RST must leave the reset-release bit set");
   end
   if (STAT_RST[SB_SELF] == 1'b1) begin : g_bad_stat_rst
      $error("STAT_RST must not report a finished self test");
   end

   cmd_act_t          act;
   logic [BYTE_W-1:0] mode_q, stat_q, outp_q, outp_view;

   kbc_cmd_decode u_dec (
      .code_i (cmd_byte),
      .act_o  (act)
   );

   kbc_avail_view u_view (
      .kbd_avail (kbd_avail),
      .aux_avail (aux_avail),
      .mode_q    (mode_q),
      .stat_q    (stat_q),
      .outp_q    (outp_q),
      .status_v  (status_o),
      .outp_v    (outp_view),
      .irq_kbd   (irq_kbd),
      .irq_aux   (irq_aux)
   );

   kbc_ctl_regs #(
      .MODE_RST   (MODE_RST),
      .STAT_RST   (STAT_RST),
      .OUTP_RST   (OUTP_RST),
      .SELF_REPLY (SELF_REPLY),
      .TEST_REPLY (TEST_REPLY),
      .DATA_FIRST (DATA_FIRST)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_wr      (cmd_wr),
      .act         (act),
      .dat_wr      (dat_wr),
      .dat_byte    (dat_byte),
      .outp_view   (outp_view),
      .mode_q      (mode_q),
      .stat_q      (stat_q),
      .outp_q      (outp_q),
      .rq_push     (rq_push),
      .rq_byte     (rq_byte),
      .rq_aux      (rq_aux),
      .dev_push    (dev_push),
      .dev_byte    (dev_byte),
      .dev_aux     (dev_aux),
      .sys_rst_req (sys_rst_req),
      .bad_cmd     (bad_cmd)
   );

   assign mode_o    = mode_q;
   assign outport_o = outp_view;

   generate
      if (HAS_GATE) begin : g_gate
         assign a20_o = outp_q[OB_GATE];
      end else begin : g_no_gate
         assign a20_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/kbc_cmd_proc_chk.sv
module kbc_cmd_proc_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_wr,
   input logic       dat_wr,
   input logic       kbd_avail,
   input logic       aux_avail,
   input logic [7:0] mode_o,
   input logic       a20_o,
   input logic       sys_rst_req,
   input logic       bad_cmd,
   input logic       irq_kbd,
   input logic       irq_aux,
   input logic       rq_push,
   input logic       dev_push
);

   // R5, R13: a reset request only follows a write
   p_rst_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |-> $past(cmd_wr || dat_wr));

   // R8: error strobe only follows a command write
   p_bad_after_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bad_cmd |-> $past(cmd_wr));

   // R8: an unsupported command pushes nothing by itself
   p_bad_no_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bad_cmd |-> (!rq_push || $past(dat_wr)));

   // R7: device forwarding only follows a data write
   p_dev_after_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dev_push |-> $past(dat_wr));

   // R2: replies only follow a write
   p_push_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rq_push |-> $past(cmd_wr || dat_wr));

   // R3: mode holds without writes
   p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_wr && !dat_wr) |=> $stable(mode_o));

   // R4: gate holds without writes
   p_gate_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_wr && !dat_wr) |=> $stable(a20_o));

   // R10: interrupts need the matching availability
   p_irq_kbd_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_kbd |-> kbd_avail);
   p_irq_aux_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_aux |-> (aux_avail && !kbd_avail));

endmodule

bind kbc_cmd_proc kbc_cmd_proc_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_wr      (cmd_wr),
   .dat_wr      (dat_wr),
   .kbd_avail   (kbd_avail),
   .aux_avail   (aux_avail),
   .mode_o      (mode_o),
   .a20_o       (a20_o),
   .sys_rst_req (sys_rst_req),
   .bad_cmd     (bad_cmd),
   .irq_kbd     (irq_kbd),
   .irq_aux     (irq_aux),
   .rq_push     (rq_push),
   .dev_push    (dev_push)
);

// File: tb/tb_kbc_cmd_proc.sv
`timescale 1ns/1ps
module tb_kbc_cmd_proc;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_wr = 1'b0, dat_wr = 1'b0;
   logic [7:0] cmd_byte = '0, dat_byte = '0;
   logic       kbd_avail = 1'b0, aux_avail = 1'b0;
   logic [7:0] status_o, mode_o, outport_o, rq_byte, dev_byte;
   logic       a20_o, sys_rst_req, bad_cmd, irq_kbd, irq_aux;
   logic       rq_push, rq_aux, dev_push, dev_aux;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   kbc_cmd_proc dut (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
      .dat_wr(dat_wr), .dat_byte(dat_byte), .kbd_avail(kbd_avail),
      .aux_avail(aux_avail), .status_o(status_o), .mode_o(mode_o),
      .outport_o(outport_o), .a20_o(a20_o), .sys_rst_req(sys_rst_req),
      .bad_cmd(bad_cmd), .irq_kbd(irq_kbd), .irq_aux(irq_aux),
      .rq_push(rq_push), .rq_byte(rq_byte), .rq_aux(rq_aux),
      .dev_push(dev_push), .dev_byte(dev_byte), .dev_aux(dev_aux)
   );

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cmd_wr = 1'b0; dat_wr = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one cycle of strobes; returns at the negedge after the capturing edge
   task automatic drive(input logic cw, input logic [7:0] cb,
                        input logic dw, input logic [7:0] db);
      @(negedge clk);
      cmd_wr = cw; cmd_byte = cb; dat_wr = dw; dat_byte = db;
      @(negedge clk);
      cmd_wr = 1'b0; dat_wr = 1'b0;
   endtask

   task automatic chk_quiet(input string req);
      chk(req, "rq_push", {7'd0, rq_push}, 8'h00);
      chk(req, "dev_push", {7'd0, dev_push}, 8'h00);
      chk(req, "sys_rst_req", {7'd0, sys_rst_req}, 8'h00);
      chk(req, "bad_cmd", {7'd0, bad_cmd}, 8'h00);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual expired expected finished");
      finish_run();
   end

   initial begin
      logic [7:0] e_mode, e_outp, e_stat, e_byte, v;
      logic       e_push, e_rst, e_bad;
      int         arm;   // 0 none,1 mode,2 outp,3 kbuf,4 abuf,5 adev

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "mode_o", mode_o, 8'h03);
      chk("R1", "status_o", status_o, 8'h18);
      chk("R1", "outport_o", outport_o, 8'h03);
      chk("R1", "a20_o", {7'd0, a20_o}, 8'h01);
      chk_quiet("R1");

      // exhaustive command sweep from the reset state
      for (int c = 0; c < 256; c++) begin
         e_mode = 8'h03; e_outp = 8'h03; e_stat = 8'h18;
         e_push = 1'b0; e_byte = 8'h00; e_rst = 1'b0; e_bad = 1'b0; arm = 0;
         if (c[7:4] == 4'hF) e_rst = ~c[0];
         else case (c[7:0])
            8'h20: begin e_push = 1'b1; e_byte = 8'h03; end
            8'h60: arm = 1;
            8'hD1: arm = 2;
            8'hD2: arm = 3;
            8'hD3: arm = 4;
            8'hD4: arm = 5;
            8'hA7: e_mode = 8'h23;
            8'hA8: e_mode = 8'h03;
            8'hAD: e_mode = 8'h13;
            8'hAE: e_mode = 8'h03;
            8'hA9, 8'hAB, 8'hC0: begin e_push = 1'b1; e_byte = 8'h00; end
            8'hAA: begin e_push = 1'b1; e_byte = 8'h55; e_stat = 8'h1C; end
            8'hD0: begin e_push = 1'b1; e_byte = 8'h03; end
            8'hDD: e_outp = 8'h01;
            8'hDF: e_outp = 8'h03;
            default: e_bad = 1'b1;
         endcase
         do_reset();
         drive(1'b1, c[7:0], 1'b0, 8'h00);
         chk("R2", $sformatf("push cmd %02h", c), {7'd0, rq_push}, {7'd0, e_push});
         if (e_push) begin
            chk("R2", $sformatf("reply cmd %02h", c), rq_byte, e_byte);
            chk("R2", $sformatf("reply aux cmd %02h", c), {7'd0, rq_aux}, 8'h00);
         end
         chk("R5", $sformatf("rst cmd %02h", c), {7'd0, sys_rst_req}, {7'd0, e_rst});
         chk("R8", $sformatf("bad cmd %02h", c), {7'd0, bad_cmd}, {7'd0, e_bad});
         chk("R3", $sformatf("mode cmd %02h", c), mode_o, e_mode);
         chk("R4", $sformatf("outport cmd %02h", c), outport_o, e_outp);
         chk("R4", $sformatf("a20 cmd %02h", c), {7'd0, a20_o}, {7'd0, e_outp[1]});
         chk("R2", $sformatf("status cmd %02h", c), status_o, e_stat);
         chk("R6", $sformatf("dev cmd %02h", c), {7'd0, dev_push}, 8'h00);
         // data phase
         v = c[7:0] ^ 8'h3C;
         drive(1'b0, 8'h00, 1'b1, v);
         case (arm)
            1: chk("R6", "mode load", mode_o, v);
            2: begin
               chk("R6", "outport load", outport_o, v & 8'hCF);
               chk("R13", "a20 from data", {7'd0, a20_o}, {7'd0, v[1]});
               chk("R13", "rst from data", {7'd0, sys_rst_req}, {7'd0, ~v[0]});
            end
            3, 4: begin
               chk("R6", "kbuf/abuf push", {7'd0, rq_push}, 8'h01);
               chk("R6", "kbuf/abuf byte", rq_byte, v);
               chk("R6", "kbuf/abuf aux", {7'd0, rq_aux}, (arm == 4) ? 8'h01 : 8'h00);
            end
            default: begin
               chk((arm == 5) ? "R6" : "R7", "dev push", {7'd0, dev_push}, 8'h01);
               chk((arm == 5) ? "R6" : "R7", "dev byte", dev_byte, v);
               chk((arm == 5) ? "R6" : "R7", "dev aux", {7'd0, dev_aux},
                   (arm == 5) ? 8'h01 : 8'h00);
               chk("R7", "no queue push", {7'd0, rq_push}, 8'h00);
            end
         endcase
         // pending cleared: next data byte goes to the keyboard device
         if (arm != 0) begin
            drive(1'b0, 8'h00, 1'b1, 8'hC3);
            chk("R6", "cleared dev push", {7'd0, dev_push}, 8'h01);
            chk("R6", "cleared dev aux", {7'd0, dev_aux}, 8'h00);
         end
      end

      // output port write with bit 0 clear
      do_reset();
      drive(1'b1, 8'hD1, 1'b0, 8'h00);
      drive(1'b0, 8'h00, 1'b1, 8'h00);
      chk("R13", "rst pulse", {7'd0, sys_rst_req}, 8'h01);
      chk("R13", "a20 low", {7'd0, a20_o}, 8'h00);
      @(negedge clk);
      chk("R13", "rst single cycle", {7'd0, sys_rst_req}, 8'h00);
      drive(1'b1, 8'hF0, 1'b0, 8'h00);
      chk("R5", "F0 pulse", {7'd0, sys_rst_req}, 8'h01);
      @(negedge clk);
      chk("R5", "F0 single cycle", {7'd0, sys_rst_req}, 8'h00);

      // availability views and interrupts over all mode values
      do_reset();
      for (int m = 0; m < 256; m++) begin
         drive(1'b1, 8'h60, 1'b0, 8'h00);
         drive(1'b0, 8'h00, 1'b1, m[7:0]);
         for (int p = 0; p < 4; p++) begin
            logic k, a, ob, ao;
            k = p[0]; a = p[1];
            kbd_avail = k; aux_avail = a;
            #1;
            ob = k | a; ao = a & ~k;
            chk("R9", "status view", status_o, 8'h18 | {2'b0, ao, 4'b0, ob});
            chk("R9", "outport view", outport_o, 8'h03 | {2'b0, ao, ob, 4'b0});
            chk("R10", "irq_kbd", {7'd0, irq_kbd}, {7'd0, k & m[0] & ~m[4]});
            chk("R10", "irq_aux", {7'd0, irq_aux}, {7'd0, a & ~k & m[1]});
         end
         kbd_avail = 1'b0; aux_avail = 1'b0;
      end

      // D0 reply carries the full flags
      do_reset();
      kbd_avail = 1'b1;
      drive(1'b1, 8'hD0, 1'b0, 8'h00);
      chk("R2", "D0 with kbd data", rq_byte, 8'h13);
      kbd_avail = 1'b0; aux_avail = 1'b1;
      drive(1'b1, 8'hD0, 1'b0, 8'h00);
      chk("R2", "D0 with aux data", rq_byte, 8'h33);
      aux_avail = 1'b0;

      // same cycle: mode load plus a mode-bit command
      do_reset();
      drive(1'b1, 8'h60, 1'b0, 8'h00);
      drive(1'b1, 8'hAD, 1'b1, 8'h41);
      chk("R11", "load then set bit4", mode_o, 8'h51);
      drive(1'b1, 8'h60, 1'b0, 8'h00);
      drive(1'b1, 8'h60, 1'b1, 8'h01);
      chk("R11", "load with rearm", mode_o, 8'h01);
      chk_quiet("R11");
      drive(1'b0, 8'h00, 1'b1, 8'h22);
      chk("R11", "rearmed load", mode_o, 8'h22);
      chk("R11", "rearmed no dev", {7'd0, dev_push}, 8'h00);
      drive(1'b1, 8'hD1, 1'b0, 8'h00);
      drive(1'b1, 8'hDF, 1'b1, 8'h01);
      chk("R11", "outport load then gate", outport_o, 8'h03);
      chk("R11", "gate high", {7'd0, a20_o}, 8'h01);

      // same cycle: queue push meets a reply
      do_reset();
      drive(1'b1, 8'hD2, 1'b0, 8'h00);
      drive(1'b1, 8'h20, 1'b1, 8'h77);
      chk("R12", "push", {7'd0, rq_push}, 8'h01);
      chk("R12", "data byte wins", rq_byte, 8'h77);
      chk("R12", "kbd queue", {7'd0, rq_aux}, 8'h00);
      @(negedge clk);
      chk("R12", "reply dropped", {7'd0, rq_push}, 8'h00);
      drive(1'b1, 8'hD3, 1'b0, 8'h00);
      drive(1'b1, 8'hAA, 1'b1, 8'h66);
      chk("R12", "aux data byte wins", rq_byte, 8'h66);
      chk("R12", "aux queue", {7'd0, rq_aux}, 8'h01);
      chk("R12", "self bit still set", status_o, 8'h1C);

      finish_run();
   end

endmodule